// File: doc/BRIEF.md
# Cache Line Decay Controller

This block switches off the supply of cache lines that have gone unused for a while, so that their leakage stops. Each of the lines of a small cache carries a 2-bit age counter. One shared tick generator advances every age counter at a fixed interval, and each access to a line clears that line's age. When a line's age reaches its top value, the line is decayed: its power enable drops and its contents count as lost, so the next access to it is reported as a miss. A dirty line is not allowed to lose its contents silently. It first raises a writeback request and powers down only after the request is acknowledged.

In adaptive mode the tick interval is not fixed. It starts at its shortest setting and is re-evaluated once every window of ticks. If any line was missed soon after it decayed, the decay was premature, and the interval doubles. If no such miss happened, the interval halves. Both steps saturate at configured bounds. The data array, the tag compare and the next memory level sit outside the block. The tag compare supplies the hit indication, and the next level answers writeback requests.

Top module: `cache_decay_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every bit of `pwr_en` is 1, `wb_req` is 0 and `cur_interval` equals TICK_DEFAULT.
- R2: `acc_miss` is combinational and equals `acc_valid && (!acc_hit || line acc_idx is decayed)` in the same cycle.
- R3: An access clears the accessed line's age counter. If an access and a tick reach the same line in the same cycle, the clear wins. A line accessed at least once per tick interval never decays.
- R4: One tick is issued every `cur_interval` cycles. Each tick raises every live line's age by one, saturating at 3. A clean line whose age is 3 is decayed on the following clock, so its `pwr_en` drops no earlier than 2·interval+1 cycles and no later than 3·interval+2 cycles after its last access.
- R5: An access to a decayed line is reported as a miss even when `acc_hit` is 1. The line's `pwr_en` returns to 1 on the next cycle, with its age cleared.
- R6: An access with `acc_write`=1 marks the line dirty. A dirty line at age 3 keeps `pwr_en` at 1 and holds `wb_req`=1 with `wb_idx` set to the lowest such line index. When `wb_ack` is high while `wb_req` is high, line `wb_idx` decays on that clock and its dirty mark clears.
- R7: While `adapt_en` is 0, `cur_interval` is TICK_DEFAULT from the next cycle on. On the first cycle in which `adapt_en` is seen high, `cur_interval` becomes TICK_MIN on the next clock.
- R8: A quick miss is an access to a decayed line within 4 ticks of its decay. In adaptive mode, the window closes on every EVAL_TICKS-th tick. At that point the interval doubles if a quick miss occurred during the window, and halves otherwise.
- R9: Adaptive doubling saturates at TICK_MAX and halving saturates at TICK_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adapt_en | input | 1 | 1 selects adaptive tick interval, 0 the fixed default |
| acc_valid | input | 1 | An access to a line occurs this cycle |
| acc_idx | input | log2(NUM_LINES) | Index of the accessed line |
| acc_write | input | 1 | The access writes the line (marks it dirty) |
| acc_hit | input | 1 | Tag compare result for the access |
| acc_miss | output | 1 | Access is a miss (tag miss or decayed line) |
| pwr_en | output | NUM_LINES | Per-line supply enable, 1 = powered |
| wb_req | output | 1 | A dirty line awaits writeback before decay |
| wb_idx | output | log2(NUM_LINES) | Line for which writeback is requested |
| wb_ack | input | 1 | Writeback of line `wb_idx` is done |
| cur_interval | output | log2(TICK_MAX)+1 | Tick interval in cycles currently in force |

## Verification
The age logic is tried with three access patterns. A line touched once and then left alone must power down inside the window predicted from the interval. A line touched once per interval must stay powered, which separates the counter clear from mere tick counting. A write followed by idle time separates the writeback hold from a clean decay. The adaptive loop is driven by idle windows, which must halve and then pin at the floor, and by repeated revive–decay–miss cycles, which must double the interval and pin it at the ceiling. Dropping back to fixed mode then shows the default interval restored.

// File: rtl/decay_pkg.sv
// Package: shared widths and types for the cache decay controller.
// Assumes a 2-bit age counter per line.
package decay_pkg;
    localparam int AGE_W = 2;
    typedef logic [AGE_W-1:0] age_t;
    localparam age_t AGE_MAX = '1;
endpackage

// File: rtl/decay_tick_gen.sv
// Module: decay_tick_gen
// Free-running tick source. Raises tick for one cycle every `interval` cycles.
// Assumes interval >= 2. If interval shrinks below the current count, the
// next cycle ticks at once.
module decay_tick_gen #(
    parameter int IV_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IV_W-1:0] interval,
    output logic            tick
);
    logic [IV_W-1:0] cnt;

    // Tick when the count has reached the interval end.
    always_comb tick = (cnt >= interval - 1'b1);

    // Count cycles and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/decay_line.sv
// Module: decay_line
// State of one cache line: age counter, decayed flag, dirty flag and a
// recent-decay flag that stays up for 4 ticks after the line decays.
// Assumes acc_sel is one-hot across lines and wb_grant only with a pending request.
module decay_line
    import decay_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic acc_sel,
    input  logic acc_write,
    input  logic wb_grant,
    output logic powered,
    output logic wb_pend,
    output logic quick_miss
);
    age_t age;
    logic decayed;
    logic dirty;
    logic recent;

    // Outputs derived from line state.
    always_comb begin
        powered    = !decayed;
        wb_pend    = !decayed && (age == AGE_MAX) && dirty;
        quick_miss = acc_sel && decayed && recent;
    end

    // Age, decay and dirty tracking. An access has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age     <= '0;
            decayed <= 1'b0;
            dirty   <= 1'b0;
            recent  <= 1'b0;
        end else if (acc_sel) begin
            age     <= '0;
            decayed <= 1'b0;
            recent  <= 1'b0;
            dirty   <= acc_write | (dirty & ~decayed);
        end else if (decayed) begin
            if (tick && recent) begin
                if (age == AGE_MAX) recent <= 1'b0;
                else age <= age + 1'b1;
            end
        end else if (age == AGE_MAX) begin
            if (!dirty || wb_grant) begin
                decayed <= 1'b1;
                recent  <= 1'b1;
                age     <= '0;
                dirty   <= 1'b0;
            end
        end else if (tick) begin
            age <= age + 1'b1;
        end
    end

    AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sel |=> (age == '0) && powered); // R3
    AST_DIRTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_pend && !wb_grant && !acc_sel) |=> powered); // R6
    AST_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !powered) |=> powered); // R5
endmodule

// File: rtl/decay_adapt.sv
// Module: decay_adapt
// Chooses the tick interval. Fixed at TICK_DEFAULT when adaptation is off.
// When on, starts at TICK_MIN and, every EVAL_TICKS ticks, doubles on a seen
// quick miss or halves otherwise, saturating at the bounds.
module decay_adapt #(
    parameter int TICK_MIN     = 64,
    parameter int TICK_DEFAULT = 2500,
    parameter int TICK_MAX     = 65536,
    parameter int EVAL_TICKS   = 16,
    parameter int IV_W         = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adapt_en,
    input  logic            tick,
    input  logic            qm_any,
    output logic [IV_W-1:0] interval
);
    localparam int WIN_W = (EVAL_TICKS > 1) ? $clog2(EVAL_TICKS) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(EVAL_TICKS - 1);
    localparam logic [IV_W:0]    MAX_X    = (IV_W+1)'(TICK_MAX);
    localparam logic [IV_W-1:0]  MIN_V    = IV_W'(TICK_MIN);
    localparam logic [IV_W-1:0]  DEF_V    = IV_W'(TICK_DEFAULT);

    logic [WIN_W-1:0] win;
    logic             seen;
    logic             en_q;
    logic [IV_W:0]    dbl_x;
    logic [IV_W-1:0]  dbl_v;
    logic [IV_W-1:0]  hlv_v;

    // Saturated doubled and halved candidates.
    always_comb begin
        dbl_x = {interval, 1'b0};
        dbl_v = (dbl_x > MAX_X) ? MAX_X[IV_W-1:0] : dbl_x[IV_W-1:0];
        hlv_v = ((interval >> 1) < MIN_V) ? MIN_V : (interval >> 1);
    end

    // Mode tracking, window counting and interval update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= DEF_V;
            en_q     <= 1'b0;
            win      <= '0;
            seen     <= 1'b0;
        end else begin
            en_q <= adapt_en;
            if (!adapt_en) begin
                interval <= DEF_V;
                win      <= '0;
                seen     <= 1'b0;
            end else if (!en_q) begin
                interval <= MIN_V;
                win      <= '0;
                seen     <= 1'b0;
            end else if (tick && win == WIN_LAST) begin
                interval <= (seen || qm_any) ? dbl_v : hlv_v;
                win      <= '0;
                seen     <= 1'b0;
            end else begin
                if (tick) win <= win + 1'b1;
                if (qm_any) seen <= 1'b1;
            end
        end
    end

    AST_IV_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && en_q) |-> (interval >= MIN_V && {1'b0, interval} <= MAX_X)); // R9
    AST_FIXED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !adapt_en |=> interval == DEF_V); // R7
endmodule

// File: rtl/cache_decay_ctrl.sv
// Module: cache_decay_ctrl (top)
// Per-line leakage control for a small cache: shared tick source, per-line
// age state, writeback arbitration for dirty lines, adaptive interval.
// Assumes NUM_LINES is a power of two and TICK_MIN >= 2.
module cache_decay_ctrl
    import decay_pkg::*;
#(
    parameter int NUM_LINES    = 32,
    parameter int TICK_MIN     = 64,
    parameter int TICK_DEFAULT = 2500,
    parameter int TICK_MAX     = 65536,
    parameter int EVAL_TICKS   = 16,
    localparam int IDX_W       = $clog2(NUM_LINES),
    localparam int IV_W        = $clog2(TICK_MAX) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adapt_en,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 acc_write,
    input  logic                 acc_hit,
    output logic                 acc_miss,
    output logic [NUM_LINES-1:0] pwr_en,
    output logic                 wb_req,
    output logic [IDX_W-1:0]     wb_idx,
    input  logic                 wb_ack,
    output logic [IV_W-1:0]      cur_interval
);
    logic                 tick;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] qm;
    logic [NUM_LINES-1:0] grant;

    decay_tick_gen #(.IV_W(IV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cur_interval),
        .tick     (tick)
    );

    decay_adapt #(
        .TICK_MIN     (TICK_MIN),
        .TICK_DEFAULT (TICK_DEFAULT),
        .TICK_MAX     (TICK_MAX),
        .EVAL_TICKS   (EVAL_TICKS),
        .IV_W         (IV_W)
    ) u_adapt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adapt_en (adapt_en),
        .tick     (tick),
        .qm_any   (|qm),
        .interval (cur_interval)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel;
        // Decode this line's access and writeback grant.
        always_comb begin
            sel      = acc_valid && (acc_idx == IDX_W'(i));
            grant[i] = wb_ack && wb_req && (wb_idx == IDX_W'(i));
        end
        decay_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .acc_sel    (sel),
            .acc_write  (acc_write),
            .wb_grant   (grant[i]),
            .powered    (pwr_en[i]),
            .wb_pend    (pend[i]),
            .quick_miss (qm[i])
        );
    end

    // Lowest-index pending dirty line wins the writeback port.
    always_comb begin
        wb_req = |pend;
        wb_idx = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (pend[k]) wb_idx = IDX_W'(k);
        end
    end

    // Miss on tag miss or on a powered-down line.
    always_comb acc_miss = acc_valid && (!acc_hit || !pwr_en[acc_idx]);

    AST_WB_LINE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> pwr_en[wb_idx]); // R6
    AST_ACK_DECAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack && !(acc_valid && acc_idx == wb_idx)) |=> !pwr_en[$past(wb_idx)]); // R6
    AST_DEAD_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && !acc_miss) |-> pwr_en[acc_idx]); // R2
endmodule

// File: tb/sim_cache_decay_ctrl.sv
module sim_cache_decay_ctrl;
    localparam int NL = 32;
    localparam int IW = 5;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adapt_en = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          acc_write = 1'b0;
    logic          acc_hit = 1'b0;
    logic          acc_miss;
    logic [NL-1:0] pwr_en;
    logic          wb_req;
    logic [IW-1:0] wb_idx;
    logic          wb_ack = 1'b0;
    logic [VW-1:0] cur_interval;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cache_decay_ctrl #(
        .NUM_LINES(NL), .TICK_MIN(4), .TICK_DEFAULT(8), .TICK_MAX(32), .EVAL_TICKS(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .acc_valid(acc_valid),
        .acc_idx(acc_idx), .acc_write(acc_write), .acc_hit(acc_hit),
        .acc_miss(acc_miss), .pwr_en(pwr_en), .wb_req(wb_req), .wb_idx(wb_idx),
        .wb_ack(wb_ack), .cur_interval(cur_interval)
    );

    // {idx[4:0], hit, expected miss} for live lines just after reset
    localparam logic [6:0] VEC [6] = '{
        {5'd0, 1'b1, 1'b0}, {5'd31, 1'b0, 1'b1}, {5'd12, 1'b1, 1'b0},
        {5'd12, 1'b0, 1'b1}, {5'd5, 1'b1, 1'b0}, {5'd20, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // One-cycle access; returns acc_miss seen during the access cycle.
    task automatic do_acc(input int idx, input bit wr, input bit hit, output bit miss);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = IW'(idx); acc_write = wr; acc_hit = hit;
        #1 miss = acc_miss;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off(input int idx);
        for (int k = 0; k < 400 && pwr_en[idx]; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwr_en", int'(pwr_en == '1), 1);
        chk("R1 wb_req", int'(wb_req), 0);
        chk("R1 interval", int'(cur_interval), 8);

        // R2 table of accesses to live lines
        for (int v = 0; v < 6; v++) begin
            do_acc(int'(VEC[v][6:2]), 1'b0, VEC[v][1], m);
            chk("R2 miss", int'(m), int'(VEC[v][0]));
        end

        // R4 clean decay window after a single access
        do_acc(3, 1'b0, 1'b1, m);
        wait_n(15);
        chk("R4 still on", int'(pwr_en[3]), 1);
        wait_n(10);
        chk("R4 decayed", int'(pwr_en[3]), 0);

        // R5 access to decayed line reports miss and revives it
        do_acc(3, 1'b0, 1'b1, m);
        chk("R5 miss on decayed", int'(m), 1);
        chk("R5 revived", int'(pwr_en[3]), 1);

        // R6 dirty line holds until ack
        do_acc(7, 1'b1, 1'b1, m);
        wait_n(27);
        chk("R6 wb_req", int'(wb_req), 1);
        chk("R6 wb_idx", int'(wb_idx), 7);
        chk("R6 held on", int'(pwr_en[7]), 1);
        wait_n(5);
        chk("R6 still held", int'(pwr_en[7]), 1);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk("R6 off after ack", int'(pwr_en[7]), 0);
        chk("R6 req cleared", int'(wb_req), 0);

        // R3 access once per interval keeps the line alive (covers tick coincidence)
        for (int r = 0; r < 16; r++) begin
            do_acc(5, 1'b0, 1'b1, m);
            wait_n(6);
        end
        chk("R3 kept alive", int'(pwr_en[5]), 1);
        wait_n(40);

        // R7 adaptive start at minimum
        @(negedge clk);
        adapt_en = 1'b1;
        @(negedge clk);
        chk("R7 start min", int'(cur_interval), 4);
        wait_n(80);
        chk("R9 floor", int'(cur_interval), 4);

        // R8 one quick miss doubles the interval
        do_acc(9, 1'b0, 1'b1, m);
        wait_off(9);
        do_acc(9, 1'b0, 1'b0, m);
        chk("R8 quick miss", int'(m), 1);
        wait_n(34);
        chk("R8 doubled", int'(cur_interval), 8);

        // R9 repeated quick misses pin at the ceiling
        for (int r = 0; r < 40; r++) begin
            do_acc(9, 1'b0, 1'b1, m);
            wait_off(9);
            do_acc(9, 1'b0, 1'b0, m);
            if (cur_interval > 32) chk("R9 above max", int'(cur_interval), 32);
        end
        chk("R9 ceiling", int'(cur_interval), 32);

        // R8 idle windows halve back to the floor
        wait_n(800);
        chk("R8 halved to min", int'(cur_interval), 4);

        // R7 leaving adaptive mode restores default
        adapt_en = 1'b0;
        @(negedge clk);
        chk("R7 default", int'(cur_interval), 8);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule